// File: doc/BRIEF.md
# Serial Result Port for a SAR Converter with Daisy-Chain Support

This block is the digital output port of a 14-bit successive-approximation converter. It takes the finished result word and a one-cycle conversion-end strobe from the converter core. It shifts the word out on a serial data pin under control of the host pins: convert (`cnv_i`), serial clock (`sck_i`), serial data in (`sdi_i`) and the fast-conversion control (`turbo_i`). All pins pass through a synchronizer and are handled in the system clock domain, so the whole port is one synchronous design with an active-high reset.

On every rising edge of the convert pin, the port picks one of two link styles. It uses the serial-in level sampled just before that edge:
- In select style, the part drives its output while the convert pin is low (3-wire) or while the serial-in pin is low (4-wire). It can put a '1' start bit ahead of the data, so the host can use that bit as an interrupt.
- In chain style, serial-in carries the output of an upstream converter. The port behaves as a shift register, so the upstream bits follow the 14 local bits.

The output enable models the high-impedance state of the data pin.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, and before any conversion has been started, `sdo_oe_o` is 0 and `sdo_o` is 0.
- R2: On a rising edge of `cnv_i`, the port latches its link style from the `sdi_i` level sampled just before the edge: 1 selects select style, and 0 selects chain style. If `sdi_i` rises together with `cnv_i`, the port uses chain style.
- R3: If `turbo_i` is 1 at the rising edge of `cnv_i`, the port uses select style whatever the level of `sdi_i`.
- R4: In select style with a loaded result, the output is enabled while `cnv_i` is 0 or `sdi_i` is 0. When both are 1, `sdo_oe_o` is 0.
- R5: Data leaves MSB first. The MSB is on `sdo_o` as soon as the part is selected. Each falling edge of `sck_i` while selected advances one bit. In select style, 0s follow the 14th bit.
- R6: In select style with `turbo_i` 0, `sdo_o` is driven 0 while the part is selected and the conversion is running. If the part is selected when `conv_done_i` pulses, the frame starts with a '1' start bit that the first falling edge of `sck_i` removes.
- R7: With `turbo_i` 1 at the convert edge, no start bit is sent, and the output stays disabled during the conversion.
- R8: In chain style, the output is enabled while `cnv_i` is 0. After the 14 local bits, `sdo_o` presents the `sdi_i` values captured at each falling edge of `sck_i`, in order.
- R9: A `conv_done_i` pulse with no convert edge since the last load is ignored. A falling edge of `sck_i` while the part is not selected does not advance the data.
- R10: A new rising edge of `cnv_i` discards any unread frame and starts a new conversion phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cnv_i | input | 1 | Convert pin; its rising edge starts a conversion and latches the link style |
| sck_i | input | 1 | Serial clock pin; data advances on its falling edge |
| sdi_i | input | 1 | Serial in: style select, 4-wire select, or upstream chain data |
| turbo_i | input | 1 | Fast-conversion control; 1 forbids chain style and the start bit |
| conv_done_i | input | 1 | One-cycle strobe marking the end of a conversion |
| result_i | input | 14 | Conversion result, valid with `conv_done_i` |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; 0 models high impedance |

## Verification
A wrong latched link style shows at the ports only after the 14th falling edge of `sck_i`. At that point a select-style port shifts 0s, while a chain-style port replays the serial-in bits, so the bench reads past the local word on every frame. A wrong busy flag shows as an extra or a missing leading '1' at the very first bit read. A wrong phase shows as an output enable that is asserted, or not, during the conversion, within a few clocks of the pin change. A bad shift or select path shifts the word by one bit position, and the first affected bit reveals it.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
  typedef enum logic {LINK_SEL = 1'b0, LINK_CHAIN = 1'b1} link_t;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_CONV = 2'd1, PH_READY = 2'd2} phase_t;
  localparam int unsigned PIN_CNV   = 0;
  localparam int unsigned PIN_SCK   = 1;
  localparam int unsigned PIN_SDI   = 2;
  localparam int unsigned PIN_TURBO = 3;
  localparam int unsigned N_PINS    = 4;
endpackage

// File: rtl/sar_pin_sync.sv
module sar_pin_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] now_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) stage_q[g] <= '0;
          else       stage_q[g] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) stage_q[g] <= '0;
          else       stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= stage_q[STAGES-1];
  end

  assign now_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/sar_link_ctrl.sv
module sar_link_ctrl
  import sar_port_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   cnv_now_i,
  input  logic   cnv_prev_i,
  input  logic   sck_now_i,
  input  logic   sck_prev_i,
  input  logic   sdi_now_i,
  input  logic   sdi_prev_i,
  input  logic   turbo_now_i,
  input  logic   conv_done_i,
  output phase_t phase_o,
  output link_t  link_o,
  output logic   sel_o,
  output logic   load_o,
  output logic   busy_o,
  output logic   shift_o,
  output logic   shift_in_o,
  output logic   wait_drive_o
);
  phase_t phase_q;
  link_t  link_q;
  logic   turbo_q;
  logic   cnv_rise;
  logic   sck_fall;
  logic   sel_now;

  assign cnv_rise = cnv_now_i & ~cnv_prev_i;
  assign sck_fall = sck_prev_i & ~sck_now_i;

  always_comb begin
    if (link_q == LINK_CHAIN) sel_now = ~cnv_now_i;
    else                      sel_now = ~cnv_now_i | ~sdi_now_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_IDLE;
      link_q  <= LINK_SEL;
      turbo_q <= 1'b0;
    end else if (cnv_rise) begin
      phase_q <= PH_CONV;
      turbo_q <= turbo_now_i;
      link_q  <= (sdi_prev_i | turbo_now_i) ? LINK_SEL : LINK_CHAIN;
    end else if (phase_q == PH_CONV && conv_done_i) begin
      phase_q <= PH_READY;
    end
  end

  assign load_o       = (phase_q == PH_CONV) && conv_done_i && !cnv_rise;
  assign busy_o       = (link_q == LINK_SEL) && !turbo_q && sel_now;
  assign shift_o      = (phase_q == PH_READY) && sel_now && sck_fall && !cnv_rise;
  assign shift_in_o   = (link_q == LINK_CHAIN) ? sdi_prev_i : 1'b0;
  assign wait_drive_o = (phase_q == PH_CONV) && (link_q == LINK_SEL) && !turbo_q && sel_now;
  assign phase_o      = phase_q;
  assign link_o       = link_q;
  assign sel_o        = sel_now;

  // R10
  conv_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cnv_rise |=> phase_q == PH_CONV);
  // R3
  turbo_link_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnv_rise && turbo_now_i) |=> link_q == LINK_SEL);
  // R2
  chain_pick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnv_rise && !sdi_prev_i && !turbo_now_i) |=> link_q == LINK_CHAIN);
  // R9
  idle_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_q == PH_IDLE && !cnv_rise) |=> phase_q == PH_IDLE);
endmodule

// File: rtl/sar_shift_path.sv
module sar_shift_path #(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              head_o
);
  logic [DATA_W-1:0] data_q;
  logic              start_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      data_q  <= '0;
      start_q <= 1'b0;
    end else if (load_i) begin
      data_q  <= word_i;
      start_q <= busy_i;
    end else if (shift_i) begin
      if (start_q) start_q <= 1'b0;
      else         data_q  <= {data_q[DATA_W-2:0], bit_i};
    end
  end

  assign head_o = start_q | data_q[DATA_W-1];

  // R6
  start_bit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && busy_i) |=> head_o);
  // R5
  msb_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && !busy_i) |=> head_o == $past(word_i[DATA_W-1]));
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
  import sar_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cnv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              turbo_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [N_PINS-1:0] pins, now_v, prev_v;
  phase_t phase;
  link_t  link;
  logic   sel, load, busy, shift, shift_in, wait_drive, head;
  logic   sdo_q, oe_q;

  always_comb begin
    pins            = '0;
    pins[PIN_CNV]   = cnv_i;
    pins[PIN_SCK]   = sck_i;
    pins[PIN_SDI]   = sdi_i;
    pins[PIN_TURBO] = turbo_i;
  end

  sar_pin_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .pin_i(pins), .now_o(now_v), .prev_o(prev_v));

  sar_link_ctrl u_ctrl (
    .clk_i(clk_i), .rst_i(rst_i),
    .cnv_now_i(now_v[PIN_CNV]), .cnv_prev_i(prev_v[PIN_CNV]),
    .sck_now_i(now_v[PIN_SCK]), .sck_prev_i(prev_v[PIN_SCK]),
    .sdi_now_i(now_v[PIN_SDI]), .sdi_prev_i(prev_v[PIN_SDI]),
    .turbo_now_i(now_v[PIN_TURBO]), .conv_done_i(conv_done_i),
    .phase_o(phase), .link_o(link), .sel_o(sel), .load_o(load), .busy_o(busy),
    .shift_o(shift), .shift_in_o(shift_in), .wait_drive_o(wait_drive));

  sar_shift_path #(.DATA_W(DATA_W)) u_path (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load), .busy_i(busy), .word_i(result_i),
    .shift_i(shift), .bit_i(shift_in), .head_o(head));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= ((phase == PH_READY) && sel) || wait_drive;
      sdo_q <= (phase == PH_READY) ? head : 1'b0;
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_oe_o = oe_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sdo_oe_o |-> $past(phase) != PH_IDLE);
  // R7
  turbo_wait_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(phase) == PH_CONV && sdo_oe_o) |-> !sdo_o);
endmodule

// File: tb/sar_serial_port_bench.sv
module sar_serial_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 14;

  logic clk = 1'b0, rst = 1'b1;
  logic cnv = 0, sck = 0, sdi = 0, turbo = 0, conv_done = 0;
  logic [W-1:0] result = '0;
  logic sdo, sdo_oe;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_serial_port u_sar_serial_port (
    .clk_i(clk), .rst_i(rst), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi), .turbo_i(turbo),
    .conv_done_i(conv_done), .result_i(result), .sdo_o(sdo), .sdo_oe_o(sdo_oe));

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic settle();
    step(8);
  endtask
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask
  task automatic done_pulse(logic [W-1:0] r);
    result = r; conv_done = 1; step(1); conv_done = 0; settle();
  endtask
  task automatic sck_fall();
    sck = 1; settle(); sck = 0; settle();
  endtask
  function automatic logic want_start(int kind, bit busy, bit tb);
    return busy && !tb && kind != 2;
  endfunction

  // kind 0: select 3-wire, 1: select 4-wire, 2: chain
  task automatic run_frame(int kind, bit busy, bit tb, logic [W-1:0] r, logic [3:0] up);
    cnv = 0; sdi = (kind == 2) ? 1'b0 : 1'b1; turbo = tb; settle();
    cnv = 1; settle();
    if (kind == 0) begin
      if (busy) begin
        cnv = 0; settle();
        chk("R6/R7 wait oe", sdo_oe, tb ? 0 : 1);
        chk("R6 wait level", sdo, 0);
      end
      done_pulse(r);
      if (!busy) begin cnv = 0; settle(); end
    end else if (kind == 1) begin
      if (busy) begin
        sdi = 0; settle();
        chk("R6/R7 wait oe 4w", sdo_oe, tb ? 0 : 1);
      end
      done_pulse(r);
      if (!busy) begin
        chk("R4 deselected", sdo_oe, 0);
        sdi = 0; settle();
      end
    end else begin
      done_pulse(r);
      cnv = 0; settle();
    end
    chk("R4/R8 enable", sdo_oe, 1);
    if (want_start(kind, busy, tb)) begin
      chk("R6 start bit", sdo, 1);
      sck_fall();
    end
    for (int i = 0; i < W; i++) begin
      chk("R5 data bit", sdo, r[W-1-i]);
      if (kind == 2) sdi = (i < 4) ? up[i] : 1'b0;
      sck_fall();
    end
    for (int j = 0; j < 4; j++) begin
      if (kind == 2) chk("R8 chained bit", sdo, up[j]);
      else           chk("R5 tail zero", sdo, 0);
      sck_fall();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5EED_0A17);
    step(4); rst = 0; settle();
    chk("R1 reset oe", sdo_oe, 0);
    chk("R1 reset sdo", sdo, 0);

    // R9: strobe with no convert edge
    cnv = 0; settle(); done_pulse(14'h2AAA);
    chk("R9 idle strobe", sdo_oe, 0);

    // R2: SDI tied to CNV -> chain
    cnv = 0; sdi = 0; turbo = 0; settle();
    cnv = 1; sdi = 1; settle(); done_pulse(14'h3FFF);
    cnv = 0; sdi = 1; settle();
    for (int i = 0; i < W; i++) sck_fall();
    chk("R2 tied pins chain", sdo, 1);

    // R3: turbo forces select style even with SDI low
    cnv = 0; sdi = 0; turbo = 1; settle();
    cnv = 1; settle(); done_pulse(14'h3FFF);
    cnv = 0; sdi = 1; settle();
    chk("R7 no start bit", sdo, 1);
    for (int i = 0; i < W; i++) sck_fall();
    chk("R3 turbo select", sdo, 0);
    turbo = 0;

    // R9: SCK while deselected (4-wire)
    cnv = 0; sdi = 1; settle(); cnv = 1; settle(); done_pulse(14'h2000);
    chk("R4 both high", sdo_oe, 0);
    sck_fall(); sck_fall();
    sdi = 0; settle();
    chk("R9 msb kept", sdo, 1);
    sck_fall();
    chk("R9 next bit", sdo, 0);

    // R10: new edge discards unread frame
    sdi = 1; cnv = 0; settle(); cnv = 1; settle();
    chk("R10 frame dropped", sdo_oe, 0);
    cnv = 0; settle();
    chk("R10 wait drive", sdo_oe, 1);
    chk("R10 wait low", sdo, 0);
    done_pulse(14'h1555);
    chk("R10 new start", sdo, 1);
    sck_fall();
    chk("R10 new msb", sdo, 0);

    for (int n = 0; n < 40; n++) begin
      int kind; bit busy, tb; logic [W-1:0] r; logic [3:0] up;
      kind = int'($urandom_range(2, 0));
      busy = 1'($urandom_range(1, 0));
      tb   = 1'($urandom_range(1, 0));
      r    = W'($urandom);
      up   = 4'($urandom);
      if (kind == 2) tb = 0;
      if (n == 0) r = '0;
      if (n == 1) r = '1;
      run_frame(kind, busy, tb, r, up);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule